// File: doc/BRIEF.md
# Manchester Word Transmitter with Sync and Parity

This block is the transmit side of a terminal on a serial command/response bus. From a 12 MHz system clock it derives a 1 MHz shift clock. When the subsystem asks for a word, it sends one 16-bit value as a bipolar Manchester II signal on a pair of outputs. Each word is 20 shift periods long: a three-bit-time sync pattern, sixteen data bits with the most significant bit first, and one odd-parity bit. The sync type is chosen separately for each word: a command/status sync or a data sync.

Parallel data reaches the encoder through two ranks. The first rank is a per-byte-lane holding register. It follows the input bus while its lane control is high and keeps its value while the control is low. The second rank copies the first rank whenever no data is being shifted. While the send strobe is high, the second rank is locked and acts as the shift register, so the subsystem may already present the next word during the current one. In a serial mode, the top input bit is used directly as the data source, one bit per shift period. An output inhibit forces the line pair low, and the synchronous reset clears a word that is in progress. If the enable is still low when a word ends, the next word follows with no gap.

Top module: `manch_word_tx`

## Requirements
- R1: `sclk` has a period of DIV system clocks. It is high for the first DIV/2 clocks of each period and low for the rest.
- R2: While `rst` is high and whenever no word is in progress, `tx_pos`, `tx_neg` and `send_data` are all low.
- R3: A word begins when `enc_en_n` is low at a falling edge of `sclk`. `sync_sel` is sampled at the following rising edge. Value 0 gives a command sync: 3 half-bits with `tx_pos` high, then 3 half-bits with `tx_neg` high. Value 1 gives the inverse pattern.
- R4: After the sync, the 16 data bits follow with bit 15 first. Each bit takes two half-bits of DIV/2 clocks each. A 1 is sent as `tx_pos` high then `tx_neg` high, and a 0 as the reverse. `tx_pos` and `tx_neg` are never high together.
- R5: The 20th bit period carries parity, coded the same way as a data bit. Its value makes the count of ones over the 16 data bits plus parity odd.
- R6: `send_data` is high for exactly 16·DIV clocks per word, covering the data bits, and it rises only together with a rising edge of `sclk`.
- R7: While `send_data` is high, changes on `din` do not alter the word being sent.
- R8: The first rank is one register per byte lane (`latch_en[0]` for bits 7:0, `latch_en[1]` for bits 15:8). A lane loads `din` while its control is high and holds its value while the control is low.
- R9: If `enc_en_n` is low at the falling edge of `sclk` inside the parity period, the next word's sync follows the parity bit with no idle gap.
- R10: While `out_inh_n` is low, both line outputs are low from the next clock on. The timing of `send_data` is unchanged.
- R11: Raising `rst` during a word ends it. Afterwards the outputs stay low until a new request is made.
- R12: With `serial_mode` high, data bit k of the word is the value of `din[15]` at the `sclk` rising edge that starts data period k. The first such edge is the one at which `send_data` rises. Parity covers these serial bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst | input | 1 | Synchronous active-high master reset |
| din | input | DATA_W | Parallel data; bit 15 is the serial source in serial mode |
| latch_en | input | LANES | Per-byte-lane load control of the first rank |
| serial_mode | input | 1 | Take data bits from `din[15]` instead of the second rank |
| enc_en_n | input | 1 | Active-low transmit request |
| sync_sel | input | 1 | 0 = command/status sync, 1 = data sync |
| out_inh_n | input | 1 | Active-low line output inhibit |
| sclk | output | 1 | Shift clock, system clock divided by DIV |
| send_data | output | 1 | High while the data bits are shifted |
| tx_pos | output | 1 | Positive line drive |
| tx_neg | output | 1 | Negative line drive |

## Verification
The embedded properties assume that the reset is synchronous and that `enc_en_n`, `sync_sel`, `din` and `out_inh_n` change only between clock edges. They make no assumption about where those changes fall within a shift period. The bench changes every input on the falling edge of the system clock. It changes the serial bit only after an observed falling edge of `sclk`, so each bit is stable for half a shift period before the edge that samples it. For a chained word, the bench sets the next `sync_sel` and `din` during the current word's data phase, well before the parity period in which they are used.

// File: rtl/manch_pkg.sv
package manch_pkg;

  // Strobes derived from the shift-clock prescaler, valid for one system clock.
  typedef struct packed {
    logic rise;        // last clock of a shift period; next edge starts a period
    logic fall;        // last clock of the first half; next edge is the sclk fall
    logic second_half; // prescaler is in the second half of the period
  } shift_tick_t;

  localparam int unsigned SYNC_SLOTS = 3;
  localparam int unsigned TAIL_SLOTS = 1;

  // Level of sync half-bit idx (0..5): command sync is three positive halves
  // followed by three negative halves; data sync is the inverse.
  function automatic logic sync_half_level(input logic data_sync, input logic [2:0] idx);
    return (idx < 3'd3) ^ data_sync;
  endfunction

endpackage

// File: rtl/tx_shift_clk.sv
module tx_shift_clk
  import manch_pkg::*;
#(
  parameter int unsigned DIV = 12
) (
  input  logic        clk,
  input  logic        rst,
  output shift_tick_t tick,
  output logic        sclk
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q;

  always_comb cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= (cnt_d < CW'(HALF));
    end
  end

  assign tick.rise        = (cnt_q == CW'(DIV - 1));
  assign tick.fall        = (cnt_q == CW'(HALF - 1));
  assign tick.second_half = (cnt_q >= CW'(HALF));
  assign sclk             = sclk_q;

  // R1
  sclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_q) |-> $past(tick.rise));

  // R1
  sclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_q) |-> $past(tick.fall));

endmodule

// File: rtl/tx_slot_seq.sv
module tx_slot_seq
  import manch_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DIV    = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  shift_tick_t tick,
  input  logic        enc_en_n,
  input  logic        sync_sel,
  output logic        active,
  output logic [$clog2(DATA_W + SYNC_SLOTS + TAIL_SLOTS)-1:0] slot,
  output logic        data_sync,
  output logic        send,
  output logic        first_data,
  output logic        enter_data,
  output logic        leave_data
);
  localparam int unsigned TOTAL    = DATA_W + SYNC_SLOTS + TAIL_SLOTS;
  localparam int unsigned SW       = $clog2(TOTAL);
  localparam int unsigned FIRST_D  = SYNC_SLOTS;
  localparam int unsigned LAST_D   = SYNC_SLOTS + DATA_W - 1;
  localparam int unsigned LAST     = TOTAL - 1;
  localparam int unsigned SEND_CYC = DATA_W * DIV;
  localparam int unsigned SCW      = $clog2(SEND_CYC + 1);

  logic          active_q, active_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          go_q, sync_q, send_q;

  always_comb begin
    active_d = active_q;
    slot_d   = slot_q;
    if (tick.rise) begin
      if (go_q) begin
        active_d = 1'b1;
        slot_d   = '0;
      end else if (active_q) begin
        if (slot_q == SW'(LAST)) begin
          active_d = 1'b0;
          slot_d   = '0;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      go_q     <= 1'b0;
      sync_q   <= 1'b0;
      send_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      slot_q   <= slot_d;
      send_q   <= active_d && (slot_d >= SW'(FIRST_D)) && (slot_d <= SW'(LAST_D));
      if (tick.rise && go_q) sync_q <= sync_sel;
      if (tick.rise) go_q <= 1'b0;
      else if (tick.fall && !enc_en_n && (!active_q || slot_q == SW'(LAST))) go_q <= 1'b1;
    end
  end

  assign active     = active_q;
  assign slot       = slot_q;
  assign data_sync  = sync_q;
  assign send       = send_q;
  assign first_data = tick.rise && active_q && (slot_q == SW'(FIRST_D - 1));
  assign enter_data = tick.rise && active_q && (slot_q >= SW'(FIRST_D - 1)) && (slot_q < SW'(LAST_D));
  assign leave_data = tick.rise && active_q && (slot_q >= SW'(FIRST_D)) && (slot_q <= SW'(LAST_D));

  // Width of the send strobe, measured independently of the slot counter.
  logic [SCW-1:0] send_len_q;
  always_ff @(posedge clk) begin
    if (rst || !send_q) send_len_q <= '0;
    else                send_len_q <= send_len_q + 1'b1;
  end

  // R6
  send_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(send_q)) |-> (send_len_q == SCW'(SEND_CYC)));

  // R6
  send_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(send_q) |-> $past(tick.rise));

endmodule

// File: rtl/tx_word_ranks.sv
module tx_word_ranks #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  latch_en,
  input  logic              send,
  input  logic              serial_mode,
  input  logic              first_data,
  input  logic              enter_data,
  input  logic              leave_data,
  output logic              cur_bit,
  output logic              parity_bit
);
  localparam int unsigned LW = DATA_W / LANES;

  logic [DATA_W-1:0] rank1_q, rank2_q;
  logic              ser_q, par_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)              rank1_q[l*LW +: LW] <= '0;
      else if (latch_en[l]) rank1_q[l*LW +: LW] <= din[l*LW +: LW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rank2_q <= '0;
      ser_q   <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      if (!send)           rank2_q <= rank1_q;
      else if (leave_data) rank2_q <= {rank2_q[DATA_W-2:0], 1'b0};
      if (enter_data) ser_q <= din[DATA_W-1];
      if (first_data)      par_q <= 1'b0;
      else if (leave_data) par_q <= par_q ^ cur_bit;
    end
  end

  assign cur_bit    = serial_mode ? ser_q : rank2_q[DATA_W-1];
  assign parity_bit = ~par_q;

  // R7
  rank2_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (send && $past(send) && !$past(leave_data)) |-> $stable(rank2_q));

endmodule

// File: rtl/tx_line_drv.sv
module tx_line_drv
  import manch_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic [$clog2(DATA_W + SYNC_SLOTS + TAIL_SLOTS)-1:0] slot,
  input  logic second_half,
  input  logic data_sync,
  input  logic cur_bit,
  input  logic parity_bit,
  input  logic out_inh_n,
  output logic tx_pos,
  output logic tx_neg
);
  localparam int unsigned SW     = $clog2(DATA_W + SYNC_SLOTS + TAIL_SLOTS);
  localparam int unsigned LAST_D = SYNC_SLOTS + DATA_W - 1;

  logic level, drive;
  logic pos_q, neg_q;

  always_comb begin
    if (slot < SW'(SYNC_SLOTS))   level = sync_half_level(data_sync, {slot[1:0], second_half});
    else if (slot <= SW'(LAST_D)) level = cur_bit ^ second_half;
    else                          level = parity_bit ^ second_half;
  end

  assign drive = active && out_inh_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      pos_q <= drive && level;
      neg_q <= drive && !level;
    end
  end

  assign tx_pos = pos_q;
  assign tx_neg = neg_q;

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(pos_q && neg_q));

  // R10
  inhibit_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!out_inh_n) |-> (!pos_q && !neg_q));

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!active) |-> (!pos_q && !neg_q));

endmodule

// File: rtl/manch_word_tx.sv
module manch_word_tx
  import manch_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DIV    = 12,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  latch_en,
  input  logic              serial_mode,
  input  logic              enc_en_n,
  input  logic              sync_sel,
  input  logic              out_inh_n,
  output logic              sclk,
  output logic              send_data,
  output logic              tx_pos,
  output logic              tx_neg
);
  localparam int unsigned SW = $clog2(DATA_W + SYNC_SLOTS + TAIL_SLOTS);

  shift_tick_t   tick;
  logic          active, data_sync, send;
  logic [SW-1:0] slot;
  logic          first_data, enter_data, leave_data;
  logic          cur_bit, parity_bit;

  tx_shift_clk #(.DIV(DIV)) u_clk (
    .clk(clk), .rst(rst), .tick(tick), .sclk(sclk)
  );

  tx_slot_seq #(.DATA_W(DATA_W), .DIV(DIV)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .enc_en_n(enc_en_n), .sync_sel(sync_sel),
    .active(active), .slot(slot), .data_sync(data_sync), .send(send),
    .first_data(first_data), .enter_data(enter_data), .leave_data(leave_data)
  );

  tx_word_ranks #(.DATA_W(DATA_W), .LANES(LANES)) u_ranks (
    .clk(clk), .rst(rst), .din(din), .latch_en(latch_en), .send(send),
    .serial_mode(serial_mode), .first_data(first_data), .enter_data(enter_data),
    .leave_data(leave_data), .cur_bit(cur_bit), .parity_bit(parity_bit)
  );

  tx_line_drv #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst(rst), .active(active), .slot(slot),
    .second_half(tick.second_half), .data_sync(data_sync), .cur_bit(cur_bit),
    .parity_bit(parity_bit), .out_inh_n(out_inh_n), .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  assign send_data = send;

endmodule

// File: tb/manch_word_tx_test.sv
module manch_word_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV    = 12;
  localparam int HALF   = DIV / 2;
  localparam int HALVES = 40;

  logic        clk = 1'b0;
  logic        rst, serial_mode, enc_en_n, sync_sel, out_inh_n;
  logic [15:0] din;
  logic [1:0]  latch_en;
  logic        sclk, send_data, tx_pos, tx_neg;

  int checks = 0, fails = 0;
  int sw_run = 0, last_w = 0;
  logic [15:0] wq [0:3];
  logic        dq [0:3];
  logic [1:0]  cap [0:HALVES*HALF-1];
  int          cap_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  manch_word_tx uut (
    .clk(clk), .rst(rst), .din(din), .latch_en(latch_en), .serial_mode(serial_mode),
    .enc_en_n(enc_en_n), .sync_sel(sync_sel), .out_inh_n(out_inh_n),
    .sclk(sclk), .send_data(send_data), .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  always @(negedge clk) begin
    if (send_data) sw_run++;
    else if (sw_run != 0) begin last_w = sw_run; sw_run = 0; end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_pair(input logic [15:0] w, input logic ds, input int h);
    logic l;
    if (h < 6)       l = (h < 3) ^ ds;
    else if (h < 38) l = w[15 - (h - 6) / 2] ^ ((h - 6) % 2 == 1);
    else             l = (~^w) ^ (h == 39);
    return {l, ~l};
  endfunction

  task automatic wait_start(output bit ok);
    int t = 0;
    while (!(tx_pos || tx_neg) && t < 200) begin @(negedge clk); t++; end
    ok = (t < 200);
  endtask

  // Sends n chained words from wq/dq; caller sets din/latch_en for word 0.
  task automatic run_words(input int n);
    bit ok;
    sync_sel = dq[0];
    repeat (4) @(negedge clk);
    enc_en_n = 1'b0;
    wait_start(ok);
    check(ok, "R3", "word start seen", ok, 1);
    for (int k = 0; k < n; k++) begin
      int bs = 0, bd = 0, bp = 0;
      for (int h = 0; h < HALVES; h++) begin
        for (int c = 0; c < HALF; c++) begin
          logic [1:0] e;
          if (!(k == 0 && h == 0 && c == 0)) @(negedge clk);
          if (c == 0 && h == 2 && k == n - 1) enc_en_n = 1'b1;
          if (c == 0 && h == 12 && k < n - 1) begin din = wq[k+1]; sync_sel = dq[k+1]; end
          e = exp_pair(wq[k], dq[k], h);
          if ({tx_pos, tx_neg} !== e) begin
            if (h < 6) bs++; else if (h < 38) bd++; else bp++;
          end
        end
      end
      check(bs == 0, "R3", "sync half mismatches", bs, 0);
      check(bd == 0, "R4", "data half mismatches", bd, 0);
      check(bp == 0, "R5", "parity half mismatches", bp, 0);
      if (k > 0) check(bs + bd + bp == 0, "R9", "chained word mismatches", bs + bd + bp, 0);
      if (k < n - 1) check(bd == 0, "R7", "din changed while shifting", bd, 0);
    end
    begin
      int nz = 0;
      repeat (2 * DIV) begin @(negedge clk); if (tx_pos || tx_neg) nz++; end
      check(nz == 0, "R2", "idle cycles with line active", nz, 0);
    end
    check(last_w == 16 * DIV, "R6", "send_data width", last_w, 16 * DIV);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; serial_mode = 1'b0; enc_en_n = 1'b1; sync_sel = 1'b0;
    out_inh_n = 1'b1; din = '0; latch_en = 2'b11;
    repeat (4) @(negedge clk);
    check(!tx_pos && !tx_neg && !send_data, "R2", "outputs in reset",
          {tx_pos, tx_neg, send_data}, 0);
    rst = 1'b0;

    // R1: shift clock shape
    begin
      int hi = 0, lo = 0;
      @(negedge clk);
      while (sclk) @(negedge clk);
      while (!sclk) @(negedge clk);
      while (sclk) begin hi++; @(negedge clk); end
      while (!sclk) begin lo++; @(negedge clk); end
      check(hi == HALF, "R1", "sclk high clocks", hi, HALF);
      check(lo == HALF, "R1", "sclk low clocks", lo, HALF);
    end

    // R3 R4 R5: edge patterns, both sync types
    begin
      logic [15:0] pats [0:5];
      pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8000;
      pats[3] = 16'h0001; pats[4] = 16'hAAAA; pats[5] = 16'h5555;
      for (int i = 0; i < 6; i++) begin
        wq[0] = pats[i]; dq[0] = i[0]; din = pats[i];
        run_words(1);
      end
    end

    // R4 R5: arithmetic sweep
    for (int k = 1; k <= 12; k++) begin
      wq[0] = 16'((k * 16'h1357) ^ (k << 9)); dq[0] = k[1]; din = wq[0];
      run_words(1);
    end

    // R9 R7: chained words with mixed sync types
    wq[0] = 16'h1234; dq[0] = 1'b0; wq[1] = 16'hFEDC; dq[1] = 1'b1; din = wq[0];
    run_words(2);
    wq[0] = 16'h0F0F; dq[0] = 1'b1; wq[1] = 16'h8421; dq[1] = 1'b1;
    wq[2] = 16'h7FFE; dq[2] = 1'b0; din = wq[0];
    run_words(3);

    // R8: first rank holds while its lane control is low
    latch_en = 2'b11; din = 16'hA55A; repeat (4) @(negedge clk);
    latch_en = 2'b00; din = 16'h3C3C;
    wq[0] = 16'hA55A; dq[0] = 1'b0;
    run_words(1);
    latch_en = 2'b01; din = 16'h1E77; repeat (4) @(negedge clk);
    latch_en = 2'b00; din = 16'h0000;
    wq[0] = 16'hA577; dq[0] = 1'b1;
    run_words(1);
    latch_en = 2'b11;

    // R10: inhibit keeps the line low, strobe timing unchanged
    begin
      int nz = 0, t = 0;
      out_inh_n = 1'b0; din = 16'hC001; repeat (4) @(negedge clk);
      enc_en_n = 1'b0;
      while (!send_data && t < 400) begin @(negedge clk); t++; if (tx_pos || tx_neg) nz++; end
      enc_en_n = 1'b1;
      while (send_data) begin @(negedge clk); if (tx_pos || tx_neg) nz++; end
      repeat (6 * DIV) begin @(negedge clk); if (tx_pos || tx_neg) nz++; end
      check(nz == 0, "R10", "line active under inhibit", nz, 0);
      check(last_w == 16 * DIV, "R10", "send width under inhibit", last_w, 16 * DIV);
      out_inh_n = 1'b1;
    end

    // R11: reset aborts a word
    begin
      int nz = 0, t = 0;
      din = 16'hFFFF; repeat (4) @(negedge clk);
      enc_en_n = 1'b0;
      while (!send_data && t < 400) begin @(negedge clk); t++; end
      enc_en_n = 1'b1;
      repeat (3 * DIV) @(negedge clk);
      rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
      @(negedge clk);
      check(!tx_pos && !tx_neg && !send_data, "R11", "outputs after abort",
            {tx_pos, tx_neg, send_data}, 0);
      repeat (25 * DIV) begin @(negedge clk); if (tx_pos || tx_neg || send_data) nz++; end
      check(nz == 0, "R11", "activity after abort", nz, 0);
    end

    // R12: serial source
    begin
      logic [15:0] sw;
      int bad = 0;
      sw = 16'hC3A5; serial_mode = 1'b1; sync_sel = 1'b1;
      din = 16'h0F0F; din[15] = sw[15];
      repeat (4) @(negedge clk);
      fork
        begin
          bit ok;
          wait_start(ok);
          cap_ok = ok;
          cap[0] = {tx_pos, tx_neg};
          for (int i = 1; i < HALVES * HALF; i++) begin @(negedge clk); cap[i] = {tx_pos, tx_neg}; end
        end
        begin
          int idx = 1, t = 0;
          logic prev;
          enc_en_n = 1'b0;
          while (!send_data && t < 400) begin @(negedge clk); t++; end
          enc_en_n = 1'b1;
          prev = sclk;
          while (send_data) begin
            @(negedge clk);
            if (prev && !sclk && idx < 16) begin din[15] = sw[15 - idx]; idx++; end
            prev = sclk;
          end
        end
      join
      for (int i = 0; i < HALVES * HALF; i++)
        if (cap[i] !== exp_pair(sw, 1'b1, i / HALF)) bad++;
      check(cap_ok == 1, "R12", "serial word start", cap_ok, 1);
      check(bad == 0, "R12", "serial word mismatches", bad, 0);
      serial_mode = 1'b0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule